// File: doc/BRIEF.md
# Packet Age Time-out Discard Unit

This unit watches the oldest packet in each of a port's three receive queues: posted writes, non-posted requests and completions. It keeps a free-running count of coarse time-base ticks and presents that count so that the queue logic can stamp each packet as it arrives. Every cycle, the unit compares the stamp of each queue's head packet with the present count. When a head packet has waited longer than the age limit, the unit pulses that queue's drop strobe, and the queue discards the packet.

Each queue class has its own drop tally, which can be read through a small register port. Reading a tally clears it, and a tally stops counting when it is full. Dropped non-posted requests and completions are left to the requester's own completion timer. A dropped posted write is the only drop that raises a request to send a non-fatal error message, and that request is held until it is acknowledged. A reporting-enable bit, a silent bit and a full posted tally can each stop that request.

Top module: `pkt_age_discard`

## Requirements
- R1: After reset the time count `now_o` is 0. It increases by one on every cycle with `tick_i` high, wrapping from 255 to 0, and holds otherwise.
- R2: Class c is 0 for posted, 1 for non-posted and 2 for completion, with stamp bits [8c+7:8c]. `drop_o[c]` is high in the same cycle exactly when `head_vld_i[c]` is high and (`now_o` − stamp) mod 256 is greater than 50.
- R3: Each cycle with `drop_o[c]` high adds one to class c's drop tally.
- R4: A tally that has reached 255 stays at 255 on further drops.
- R5: A read (`reg_rd_i`) with `reg_sel_i` = c returns the tally on `reg_rdata_o` from the next cycle and clears it to 0. If a drop of class c happens in the same cycle, the read returns the old value and the tally becomes 1.
- R6: With reporting enabled and silent clear, a posted drop while the posted tally is below 255 sets `msg_req_o` from the next cycle. The request stays high until a cycle with `msg_ack_i` high and no new qualifying drop.
- R7: Non-posted and completion drops never set `msg_req_o`.
- R8: With the silent bit set, posted drops do not set `msg_req_o`, but the posted tally still counts them.
- R9: A posted drop that occurs while the posted tally already reads 255 does not set `msg_req_o`.
- R10: The control register is at `reg_sel_i` = 3. Bit 0 is reporting enable and bit 1 is silent. Both are 0 after reset. A write (`reg_wr_i`) loads them from `reg_wdata_i`, and a read returns them in `reg_rdata_o[1:0]`. Writes to other selects are ignored.
- R11: With reporting enable at 0, posted drops do not set `msg_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle time-base tick |
| now_o | output | 8 | Present time count, used as the arrival stamp |
| head_vld_i | input | 3 | Head packet present, one bit per class |
| head_ts_i | input | 24 | Arrival stamps of the head packets, 8 bits per class |
| drop_o | output | 3 | Discard strobe for the head packet, one bit per class |
| msg_req_o | output | 1 | Non-fatal error message request |
| msg_ack_i | input | 1 | Message request accepted |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0..2 tallies, 3 control |
| reg_wdata_i | input | 2 | Control write data |
| reg_rdata_o | output | 8 | Registered read data |

## Verification
Assertions check a number of rules on every cycle. They check time-count stepping, that a drop strobe only comes with a valid head, that tallies increment and stay full at 255, and that a read which collides with a drop leaves the tally at 1. They also check that a pending request holds until it is acknowledged, and that a request cannot appear while the silent bit, a disabled report or a full tally is in force. The bench's scenarios are needed to show several other behaviours. These include the exact age boundary at 50 against 51 ticks and the comparison across wrap-around, and that the read value is the old tally. They also include that non-posted and completion drops never raise a request and that the control register reads back correctly.

// File: rtl/pad_pkg.sv
package pad_pkg;
    localparam int NCLS = 3;
    localparam int SEL_W = 2;
    typedef enum logic [SEL_W-1:0] {
        SEL_POSTED = 2'd0,
        SEL_NONPOSTED = 2'd1,
        SEL_COMPL = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;
endpackage

// File: rtl/pad_age_check.sv
module pad_age_check #(
    parameter int TS_W  = 8,
    parameter int LIMIT = 50
) (
    input  logic            head_vld_i,
    input  logic [TS_W-1:0] head_ts_i,
    input  logic [TS_W-1:0] now_i,
    output logic            drop_o
);
    localparam logic [TS_W-1:0] LIM = TS_W'(LIMIT);

    logic [TS_W-1:0] age;

    always_comb begin
        age    = now_i - head_ts_i;
        drop_o = head_vld_i && (age > LIM);
    end

    always_comb begin
        assert_drop_needs_head_R2: assert (!drop_o || head_vld_i);
    end
endmodule

// File: rtl/pad_drop_ctr.sv
module pad_drop_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             sat_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d.cnt = inc_i ? ONE : '0;
        end else if (inc_i && (state_q.cnt != MAXV)) begin
            state_d.cnt = state_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign cnt_o = state_q.cnt;
    assign sat_o = (state_q.cnt == MAXV);

    assert_inc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !clr_i && !sat_o) |=> (cnt_o == $past(cnt_o) + ONE));
    assert_sat_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sat_o && !clr_i) |=> sat_o);
    assert_rd_collide_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && inc_i) |=> (cnt_o == ONE));
    assert_rd_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !inc_i) |=> (cnt_o == '0));
endmodule

// File: rtl/pad_err_msg.sv
module pad_err_msg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic drop_i,
    input  logic en_i,
    input  logic silent_i,
    input  logic sat_i,
    input  logic ack_i,
    output logic req_o
);
    typedef struct packed {
        logic req;
    } state_t;

    state_t state_d, state_q;
    logic   set;

    always_comb begin
        set     = drop_i && en_i && !silent_i && !sat_i;
        state_d = state_q;
        if (set)                       state_d.req = 1'b1;
        else if (state_q.req && ack_i) state_d.req = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign req_o = state_q.req;

    assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !ack_i) |=> req_o);
    assert_silent_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_o && silent_i) |=> !req_o);
    assert_sat_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_o && sat_i) |=> !req_o);
    assert_disabled_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_o && !en_i) |=> !req_o);
endmodule

// File: rtl/pkt_age_discard.sv
module pkt_age_discard #(
    parameter int TS_W  = 8,
    parameter int CNT_W = 8,
    parameter int LIMIT = 50
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          tick_i,
    output logic [TS_W-1:0]               now_o,
    input  logic [pad_pkg::NCLS-1:0]      head_vld_i,
    input  logic [pad_pkg::NCLS*TS_W-1:0] head_ts_i,
    output logic [pad_pkg::NCLS-1:0]      drop_o,
    output logic                          msg_req_o,
    input  logic                          msg_ack_i,
    input  logic                          reg_rd_i,
    input  logic                          reg_wr_i,
    input  logic [pad_pkg::SEL_W-1:0]     reg_sel_i,
    input  logic [1:0]                    reg_wdata_i,
    output logic [CNT_W-1:0]              reg_rdata_o
);
    import pad_pkg::*;

    localparam logic [TS_W-1:0] TS_ONE = TS_W'(1);

    typedef struct packed {
        logic [TS_W-1:0]  now;
        logic             en;
        logic             silent;
        logic [CNT_W-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NCLS-1:0]            clr;
    logic [NCLS-1:0]            sat;
    logic [NCLS-1:0][CNT_W-1:0] cnt;

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        pad_age_check #(.TS_W(TS_W), .LIMIT(LIMIT)) i_age (
            .head_vld_i (head_vld_i[c]),
            .head_ts_i  (head_ts_i[c*TS_W +: TS_W]),
            .now_i      (state_q.now),
            .drop_o     (drop_o[c])
        );

        assign clr[c] = reg_rd_i && (reg_sel_i == SEL_W'(c));

        pad_drop_ctr #(.CNT_W(CNT_W)) i_ctr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .inc_i  (drop_o[c]),
            .clr_i  (clr[c]),
            .cnt_o  (cnt[c]),
            .sat_o  (sat[c])
        );
    end

    pad_err_msg i_msg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .drop_i   (drop_o[SEL_POSTED]),
        .en_i     (state_q.en),
        .silent_i (state_q.silent),
        .sat_i    (sat[SEL_POSTED]),
        .ack_i    (msg_ack_i),
        .req_o    (msg_req_o)
    );

    always_comb begin
        state_d = state_q;
        if (tick_i) state_d.now = state_q.now + TS_ONE;
        if (reg_wr_i && (reg_sel_i == SEL_CTRL)) begin
            state_d.en     = reg_wdata_i[0];
            state_d.silent = reg_wdata_i[1];
        end
        if (reg_rd_i) begin
            case (reg_sel_i)
                SEL_POSTED:    state_d.rdata = cnt[SEL_POSTED];
                SEL_NONPOSTED: state_d.rdata = cnt[SEL_NONPOSTED];
                SEL_COMPL:     state_d.rdata = cnt[SEL_COMPL];
                default:       state_d.rdata = CNT_W'({state_q.silent, state_q.en});
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    assign now_o       = state_q.now;
    assign reg_rdata_o = state_q.rdata;

    assert_tick_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (now_o == $past(now_o) + TS_ONE));
    assert_tick_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(now_o));
    assert_ctrl_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(reg_wr_i && reg_sel_i == SEL_CTRL) |=> ($stable(state_q.en) && $stable(state_q.silent)));
endmodule

// File: tb/test_pkt_age_discard.sv
module test_pkt_age_discard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  now;
    logic [2:0]  hv = '0;
    logic [7:0]  ts [3];
    logic [2:0]  drop;
    logic        msg_req;
    logic        ack = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  sel = '0;
    logic [1:0]  wd = '0;
    logic [7:0]  rdata;

    int n_cmp = 0;
    int n_err = 0;
    bit done = 0;

    int m_now = 0, m_en = 0, m_sil = 0, m_req = 0, m_rdata = 0;
    int m_cnt [3] = '{0, 0, 0};

    always #10 clk = ~clk;

    pkt_age_discard i_pkt_age_discard (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .now_o(now),
        .head_vld_i(hv), .head_ts_i({ts[2], ts[1], ts[0]}), .drop_o(drop),
        .msg_req_o(msg_req), .msg_ack_i(ack), .reg_rd_i(rd), .reg_wr_i(wr),
        .reg_sel_i(sel), .reg_wdata_i(wd), .reg_rdata_o(rdata)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_drop();
        int d = 0;
        for (int c = 0; c < 3; c++)
            if (hv[c] && (((m_now - int'(ts[c])) % 256 + 256) % 256) > 50) d |= (1 << c);
        return d;
    endfunction

    task automatic cyc();
        int d;
        int old0;
        #8;
        d = exp_drop();
        chk("R2 drop", int'(drop), d);
        chk("R6 msg_req", int'(msg_req), m_req);
        chk("R5 rdata", int'(rdata), m_rdata);
        chk("R1 now", int'(now), m_now);
        @(posedge clk);
        old0 = m_cnt[0];
        if (rd) m_rdata = (sel < 3) ? m_cnt[sel] : (m_sil * 2 + m_en);
        for (int c = 0; c < 3; c++) begin
            if (rd && int'(sel) == c) m_cnt[c] = d[c] ? 1 : 0;
            else if (d[c] && m_cnt[c] < 255) m_cnt[c]++;
        end
        if (d[0] && m_en != 0 && m_sil == 0 && old0 != 255) m_req = 1;
        else if (m_req != 0 && ack) m_req = 0;
        if (wr && sel == 2'd3) begin
            m_en = wd[0];
            m_sil = wd[1];
        end
        if (tick) m_now = (m_now + 1) % 256;
        @(negedge clk);
    endtask

    task automatic rdreg(input logic [1:0] s, output int v);
        rd = 1'b1; sel = s;
        cyc();
        rd = 1'b0;
        v = int'(rdata);
    endtask

    task automatic wrctl(input logic [1:0] v);
        wr = 1'b1; sel = 2'd3; wd = v;
        cyc();
        wr = 1'b0;
    endtask

    initial begin
        int v;
        ts[0] = '0; ts[1] = '0; ts[2] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset now", int'(now), 0);
        chk("R6 reset msg", int'(msg_req), 0);
        rdreg(2'd3, v);
        chk("R10 ctrl reset", v, 0);
        wrctl(2'b01);
        rdreg(2'd3, v);
        chk("R10 ctrl readback", v, 1);
        wr = 1'b1; sel = 2'd1; wd = 2'b10; cyc(); wr = 1'b0;
        rdreg(2'd3, v);
        chk("R10 write other select ignored", v, 1);

        tick = 1'b1;
        repeat (60) cyc();
        tick = 1'b0;
        chk("R1 count", int'(now), 60);

        hv = 3'b001; ts[0] = 8'd10; #1;
        chk("R2 age 50 kept", int'(drop), 0);
        cyc();
        ts[0] = 8'd9; #1;
        chk("R2 age 51 dropped", int'(drop), 1);
        cyc();
        hv = '0;
        chk("R6 request raised", int'(msg_req), 1);
        cyc(); cyc();
        chk("R6 request held", int'(msg_req), 1);
        ack = 1'b1; cyc(); ack = 1'b0;
        chk("R6 request cleared", int'(msg_req), 0);

        hv = 3'b110; ts[1] = 8'd0; ts[2] = 8'd0;
        cyc(); cyc();
        hv = 3'b010;
        cyc();
        hv = '0;
        cyc();
        chk("R7 no request from np/cpl", int'(msg_req), 0);
        rdreg(2'd1, v);
        chk("R3 np tally", v, 3);
        rdreg(2'd1, v);
        chk("R5 cleared on read", v, 0);
        rdreg(2'd2, v);
        chk("R3 cpl tally", v, 2);

        tick = 1'b1;
        repeat (200) cyc();
        tick = 1'b0;
        chk("R1 wrap", int'(now), 4);
        hv = 3'b001; ts[0] = 8'd210; #1;
        chk("R2 wrap age 50 kept", int'(drop), 0);
        cyc();
        ts[0] = 8'd200; #1;
        chk("R2 wrap age 60 dropped", int'(drop), 1);
        cyc();
        hv = '0;
        ack = 1'b1; cyc(); ack = 1'b0;
        rdreg(2'd0, v);
        chk("R3 posted tally", v, 2);

        hv = 3'b010; ts[1] = 8'd200;
        cyc(); cyc();
        rdreg(2'd1, v);
        hv = '0;
        chk("R5 read with drop returns old", v, 2);
        rdreg(2'd1, v);
        chk("R5 tally left at 1", v, 1);

        wrctl(2'b11);
        hv = 3'b001; cyc(); hv = '0; cyc();
        chk("R8 silent no request", int'(msg_req), 0);
        rdreg(2'd0, v);
        chk("R8 silent still counts", v, 1);

        wrctl(2'b00);
        hv = 3'b001; cyc(); hv = '0; cyc();
        chk("R11 disabled no request", int'(msg_req), 0);
        rdreg(2'd0, v);
        chk("R11 disabled still counts", v, 1);

        wrctl(2'b01);
        ack = 1'b1; hv = 3'b001;
        repeat (300) cyc();
        hv = '0;
        cyc(); cyc();
        ack = 1'b0;
        chk("R6 acked after burst", int'(msg_req), 0);
        hv = 3'b001; cyc(); hv = '0; cyc();
        chk("R9 full tally no request", int'(msg_req), 0);
        rdreg(2'd0, v);
        chk("R4 saturated", v, 255);
        rdreg(2'd0, v);
        chk("R5 cleared after saturation", v, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++;
            n_err++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
            $finish;
        end
    end
endmodule